// File: doc/BRIEF.md
# Packed BCD Byte Add/Subtract Unit

This unit performs one step of decimal arithmetic on a byte that holds two packed BCD digits. A caller presents a destination byte and a source byte, selects add or subtract, and supplies the incoming extend flag and the incoming zero flag. The unit adds or subtracts the two bytes with the extend flag as carry-in or borrow-in, and applies a decimal correction so that valid BCD operands give a valid BCD result. On the clock edge after a valid strobe it registers the result byte, the carry, extend, overflow, zero and negative flags, and a one-cycle done pulse.

The correction is decided in two places. First the low digits alone are combined, and their intermediate value chooses the low-digit correction. That choice also moves the threshold that the raw byte is compared against to decide the high-digit correction. Carry and overflow are derived from the correction step as well as the raw operation, so bytes that are not valid BCD still produce fully defined results. The zero flag only ever clears, which lets a caller chain bytes of a longer number through an external loop and test the whole number for zero at the end.

Top module: `dec_byte_arith`

## Requirements
- R1: The low digits of both operands (bits 3:0) are combined as an unsigned byte, `a - b - x` when `op_sub`=1 or `a + b + x` when `op_sub`=0, with wrap-around below zero; when that byte value is 10 or more the low correction is 6, otherwise it is 0.
- R2: The high-digit threshold is 0xA0 when the low correction is 0; with a low correction of 6 it is 0x9A for addition and 0xA6 for subtraction.
- R3: The full bytes are combined as `a + b + x` or `a - b - x`; if that raw operation carries out or borrows, or its 8-bit raw result is unsigned at or above the threshold, the carry is set and 0x60 is added into the correction value.
- R4: The result byte is the raw byte plus the correction value (addition) or minus it (subtraction), modulo 256; if this correction step itself carries or borrows, the carry is also set.
- R5: The overflow flag is the two's-complement overflow of the correction step (raw byte plus or minus the correction value), not of the raw operation.
- R6: The extend output always equals the carry output of the same operation.
- R7: The zero output is 0 when the result byte is nonzero and equals `z_in` when the result byte is zero.
- R8: The negative output equals bit 7 of the result byte.
- R9: Outputs are updated on the rising edge after `op_valid` is sampled high; `done_q` is high for exactly those cycles; with `op_valid` low the operands and flags are ignored and every output holds.
- R10: While `rst_n` is low, the result, all flags and `done_q` read 0; reset is applied at once and released through a two-stage synchronizer.
- R11: For operands whose both digits are 0-9, the result is the decimal sum or difference modulo 100 in BCD, and the carry is set exactly when the decimal sum reaches 100 or the decimal difference is negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation strobe; one operation per high cycle |
| op_sub | input | 1 | 0 selects addition, 1 selects subtraction (a minus b) |
| opnd_a | input | 2*DIGIT_W (8) | Destination operand, minuend when subtracting |
| opnd_b | input | 2*DIGIT_W (8) | Source operand, subtrahend when subtracting |
| x_in | input | 1 | Incoming extend flag, used as carry-in or borrow-in |
| z_in | input | 1 | Incoming zero flag |
| res_q | output | 2*DIGIT_W (8) | Registered corrected result |
| c_q | output | 1 | Registered carry |
| x_q | output | 1 | Registered extend (copy of carry) |
| v_q | output | 1 | Registered overflow of the correction step |
| z_q | output | 1 | Registered sticky zero |
| n_q | output | 1 | Registered negative (result bit 7) |
| done_q | output | 1 | One-cycle pulse per accepted operation |

## Verification
The bench builds the unit with its default digit width of four bits, the only width at which the decimal thresholds carry their meaning; at that size every pair of valid BCD operands fits in a short run, so all 10,000 pairs are applied for both operations and both extend values and are checked against plain decimal arithmetic. A strided sweep over every destination byte with one source byte in five reaches the non-BCD region where the moving threshold and the correction-step carry decide the outcome. Hand-worked vectors pin the threshold edges 0x9A, 0xA0 and 0xA6, a carry raised only by the correction, and an overflow raised only by the correction.

// File: rtl/dec_arith_pkg.sv
package dec_arith_pkg;

  // Number base of one digit; the correction constants derive from it.
  localparam int unsigned DEC_RADIX = 10;

  // Condition flags produced by one byte operation.
  typedef struct packed {
    logic c;
    logic x;
    logic v;
    logic z;
    logic n;
  } dec_flags_t;

endpackage

// File: rtl/dec_rst_sync.sv
module dec_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_sh;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_sh <= '0;
    end else begin
      sync_sh <= {sync_sh[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = sync_sh[STAGES-1];

endmodule

// File: rtl/dec_low_digit.sv
module dec_low_digit #(
  parameter int DIGIT_W = 4
) (
  input  logic [DIGIT_W-1:0]   a_lo,
  input  logic [DIGIT_W-1:0]   b_lo,
  input  logic                 sub_sel,
  input  logic                 ext_in,
  output logic                 low_fix,
  output logic [2*DIGIT_W-1:0] hi_thr
);

  localparam int BYTE_W = 2 * DIGIT_W;
  localparam logic [BYTE_W-1:0] LIM    = BYTE_W'(dec_arith_pkg::DEC_RADIX);
  localparam logic [BYTE_W-1:0] ADJ    = BYTE_W'((1 << DIGIT_W) - dec_arith_pkg::DEC_RADIX);
  localparam logic [BYTE_W-1:0] HI_LIM = LIM << DIGIT_W;

  logic [BYTE_W-1:0] a_ext;
  logic [BYTE_W-1:0] b_ext;
  logic [BYTE_W-1:0] x_ext;
  logic [BYTE_W-1:0] lo_val;

  assign a_ext = BYTE_W'(a_lo);
  assign b_ext = BYTE_W'(b_lo);
  assign x_ext = BYTE_W'(ext_in);

  // Byte-wide so that a negative low difference wraps to a large value.
  always_comb begin
    if (sub_sel) begin
      lo_val = a_ext - b_ext - x_ext;
    end else begin
      lo_val = a_ext + b_ext + x_ext;
    end
  end

  assign low_fix = (lo_val >= LIM);

  // Threshold shifts by the low correction, in the direction of the operation.
  always_comb begin
    if (!low_fix) begin
      hi_thr = HI_LIM;
    end else if (sub_sel) begin
      hi_thr = HI_LIM + ADJ;
    end else begin
      hi_thr = HI_LIM - ADJ;
    end
  end

endmodule

// File: rtl/dec_byte_raw.sv
module dec_byte_raw #(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] a_in,
  input  logic [BYTE_W-1:0] b_in,
  input  logic              sub_sel,
  input  logic              ext_in,
  output logic [BYTE_W-1:0] raw,
  output logic              raw_out
);

  localparam int EW = BYTE_W + 1;

  logic [EW-1:0] full;

  // The extra top bit is the carry on add and the borrow on subtract.
  always_comb begin
    if (sub_sel) begin
      full = EW'(a_in) - EW'(b_in) - EW'(ext_in);
    end else begin
      full = EW'(a_in) + EW'(b_in) + EW'(ext_in);
    end
  end

  assign raw     = full[BYTE_W-1:0];
  assign raw_out = full[EW-1];

endmodule

// File: rtl/dec_fixup.sv
module dec_fixup #(
  parameter int DIGIT_W = 4
) (
  input  logic [2*DIGIT_W-1:0] raw,
  input  logic                 raw_out,
  input  logic                 low_fix,
  input  logic [2*DIGIT_W-1:0] hi_thr,
  input  logic                 sub_sel,
  output logic [2*DIGIT_W-1:0] res,
  output logic                 carry,
  output logic                 ovf
);

  localparam int BYTE_W = 2 * DIGIT_W;
  localparam int EW     = BYTE_W + 1;
  localparam int MSB    = BYTE_W - 1;
  localparam logic [BYTE_W-1:0] ADJ    = BYTE_W'((1 << DIGIT_W) - dec_arith_pkg::DEC_RADIX);
  localparam logic [BYTE_W-1:0] FIX_HI = ADJ << DIGIT_W;

  logic              hi_fix;
  logic [BYTE_W-1:0] fix_val;
  logic [EW-1:0]     fixed;

  assign hi_fix = raw_out | (raw >= hi_thr);

  always_comb begin
    fix_val = '0;
    if (hi_fix) begin
      fix_val = fix_val | FIX_HI;
    end
    if (low_fix) begin
      fix_val = fix_val | ADJ;
    end
  end

  always_comb begin
    if (sub_sel) begin
      fixed = EW'(raw) - EW'(fix_val);
    end else begin
      fixed = EW'(raw) + EW'(fix_val);
    end
  end

  assign res   = fixed[BYTE_W-1:0];
  assign carry = hi_fix | fixed[EW-1];

  // Signed overflow of the correction step only.
  always_comb begin
    if (sub_sel) begin
      ovf = (raw[MSB] & ~fix_val[MSB] & ~res[MSB]) |
            (~raw[MSB] & fix_val[MSB] & res[MSB]);
    end else begin
      ovf = (~raw[MSB] & ~fix_val[MSB] & res[MSB]) |
            (raw[MSB] & fix_val[MSB] & ~res[MSB]);
    end
  end

endmodule

// File: rtl/dec_byte_arith.sv
module dec_byte_arith
  import dec_arith_pkg::*;
#(
  parameter int DIGIT_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 op_valid,
  input  logic                 op_sub,
  input  logic [2*DIGIT_W-1:0] opnd_a,
  input  logic [2*DIGIT_W-1:0] opnd_b,
  input  logic                 x_in,
  input  logic                 z_in,
  output logic [2*DIGIT_W-1:0] res_q,
  output logic                 c_q,
  output logic                 x_q,
  output logic                 v_q,
  output logic                 z_q,
  output logic                 n_q,
  output logic                 done_q
);

  localparam int BYTE_W = 2 * DIGIT_W;

  logic              srst_n;
  logic              low_fix;
  logic [BYTE_W-1:0] hi_thr;
  logic [BYTE_W-1:0] raw;
  logic              raw_out;
  logic [BYTE_W-1:0] fx_res;
  logic              fx_c;
  logic              fx_v;

  logic [BYTE_W-1:0] res_cur;
  logic [BYTE_W-1:0] res_nxt;
  dec_flags_t        flg_cur;
  dec_flags_t        flg_nxt;
  logic              done_cur;
  logic              done_nxt;

  dec_rst_sync #(.STAGES(2)) u_rsync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  dec_low_digit #(.DIGIT_W(DIGIT_W)) u_low (
    .a_lo    (opnd_a[DIGIT_W-1:0]),
    .b_lo    (opnd_b[DIGIT_W-1:0]),
    .sub_sel (op_sub),
    .ext_in  (x_in),
    .low_fix (low_fix),
    .hi_thr  (hi_thr)
  );

  dec_byte_raw #(.BYTE_W(BYTE_W)) u_raw (
    .a_in    (opnd_a),
    .b_in    (opnd_b),
    .sub_sel (op_sub),
    .ext_in  (x_in),
    .raw     (raw),
    .raw_out (raw_out)
  );

  dec_fixup #(.DIGIT_W(DIGIT_W)) u_fix (
    .raw     (raw),
    .raw_out (raw_out),
    .low_fix (low_fix),
    .hi_thr  (hi_thr),
    .sub_sel (op_sub),
    .res     (fx_res),
    .carry   (fx_c),
    .ovf     (fx_v)
  );

  // Next state: the strobe is the clock enable of every output register.
  always_comb begin
    res_nxt  = res_cur;
    flg_nxt  = flg_cur;
    done_nxt = 1'b0;
    if (op_valid) begin
      res_nxt   = fx_res;
      flg_nxt.c = fx_c;
      flg_nxt.x = fx_c;
      flg_nxt.v = fx_v;
      flg_nxt.z = (fx_res == '0) ? z_in : 1'b0;
      flg_nxt.n = fx_res[BYTE_W-1];
      done_nxt  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      res_cur  <= '0;
      flg_cur  <= '0;
      done_cur <= 1'b0;
    end else begin
      res_cur  <= res_nxt;
      flg_cur  <= flg_nxt;
      done_cur <= done_nxt;
    end
  end

  assign res_q  = res_cur;
  assign c_q    = flg_cur.c;
  assign x_q    = flg_cur.x;
  assign v_q    = flg_cur.v;
  assign z_q    = flg_cur.z;
  assign n_q    = flg_cur.n;
  assign done_q = done_cur;

endmodule

// File: rtl/dec_byte_arith_chk.sv
module dec_byte_arith_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic              op_sub,
  input logic [BYTE_W-1:0] opnd_a,
  input logic [BYTE_W-1:0] opnd_b,
  input logic              x_in,
  input logic              z_in,
  input logic [BYTE_W-1:0] res_q,
  input logic              c_q,
  input logic              v_q,
  input logic              z_q,
  input logic              done_q
);

  localparam int EW = BYTE_W + 1;

  logic [EW-1:0] sum_full;
  logic          sub_borrow;

  assign sum_full   = EW'(opnd_a) + EW'(opnd_b) + EW'(x_in);
  assign sub_borrow = EW'(opnd_a) < (EW'(opnd_b) + EW'(x_in));

  // R3
  add_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_sub && sum_full[EW-1]) |=> c_q);

  // R3
  sub_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sub && sub_borrow) |=> c_q);

  // R5
  add_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_sub && sum_full[BYTE_W-1]) |=> !v_q);

  // R7
  zero_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !z_in) |=> !z_q);

  // R9
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(op_valid));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(res_q) && !done_q));

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> (res_q == '0 && !c_q && !done_q));

endmodule

bind dec_byte_arith dec_byte_arith_chk #(.BYTE_W(2 * DIGIT_W)) u_chk (
  .clk      (clk),
  .rst_n    (srst_n),
  .op_valid (op_valid),
  .op_sub   (op_sub),
  .opnd_a   (opnd_a),
  .opnd_b   (opnd_b),
  .x_in     (x_in),
  .z_in     (z_in),
  .res_q    (res_q),
  .c_q      (c_q),
  .v_q      (v_q),
  .z_q      (z_q),
  .done_q   (done_q)
);

// File: tb/dec_byte_arith_bench.sv
module dec_byte_arith_bench;

  logic       clk;
  logic       rst_n;
  logic       op_valid;
  logic       op_sub;
  logic [7:0] opnd_a;
  logic [7:0] opnd_b;
  logic       x_in;
  logic       z_in;
  logic [7:0] res_q;
  logic       c_q;
  logic       x_q;
  logic       v_q;
  logic       z_q;
  logic       n_q;
  logic       done_q;

  int nchk;
  int nfail;
  bit finished;

  dec_byte_arith #(.DIGIT_W(4)) u_dec_byte_arith (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_sub   (op_sub),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .x_in     (x_in),
    .z_in     (z_in),
    .res_q    (res_q),
    .c_q      (c_q),
    .x_q      (x_q),
    .v_q      (v_q),
    .z_q      (z_q),
    .n_q      (n_q),
    .done_q   (done_q)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Hand-worked vectors: [30] sub, [29] x, [28] z_in, [27:20] a, [19:12] b,
  // [11:4] result, [3] c, [2] v, [1] z, [0] n.
  localparam int NVEC = 18;
  localparam logic [30:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 1'b1, 8'h15, 8'h27, 8'h42, 4'b0000},
    {1'b0, 1'b0, 1'b1, 8'h99, 8'h01, 8'h00, 4'b1010},
    {1'b0, 1'b1, 1'b0, 8'h99, 8'h99, 8'h99, 4'b1101},
    {1'b0, 1'b0, 1'b1, 8'h45, 8'h45, 8'h90, 4'b0001},
    {1'b0, 1'b0, 1'b1, 8'h00, 8'h00, 8'h00, 4'b0010},
    {1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 4'b0000},
    {1'b1, 1'b0, 1'b1, 8'h42, 8'h15, 8'h27, 4'b0000},
    {1'b1, 1'b0, 1'b1, 8'h00, 8'h01, 8'h99, 4'b1001},
    {1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 8'h99, 4'b1001},
    {1'b1, 1'b0, 1'b1, 8'h50, 8'h00, 8'h50, 4'b0000},
    {1'b0, 1'b0, 1'b1, 8'h0F, 8'h00, 8'h15, 4'b0000},
    {1'b0, 1'b0, 1'b1, 8'hFF, 8'h00, 8'h65, 4'b1000},
    {1'b0, 1'b0, 1'b1, 8'hA0, 8'h00, 8'h00, 4'b1010},
    {1'b1, 1'b0, 1'b1, 8'hA0, 8'h00, 8'h40, 4'b1100},
    {1'b0, 1'b0, 1'b1, 8'h89, 8'h09, 8'h98, 4'b0001},
    {1'b1, 1'b0, 1'b0, 8'hAC, 8'h01, 8'h45, 4'b1100},
    {1'b1, 1'b0, 1'b0, 8'hA2, 8'h03, 8'h99, 4'b0001},
    {1'b1, 1'b0, 1'b0, 8'h10, 8'h0F, 8'hFB, 4'b1001}
  };

  // Model of R1..R8: returns {result, c, v, z, n}.
  function automatic logic [11:0] ref_calc(input logic sub, input logic xi,
                                           input logic zi, input logic [7:0] a,
                                           input logic [7:0] b);
    int lo, thr, corr, raw, res, sraw, sres;
    logic c, v, zo;
    if (sub) lo = (int'(a[3:0]) - int'(b[3:0]) - int'(xi)) & 255;
    else     lo = int'(a[3:0]) + int'(b[3:0]) + int'(xi);
    corr = (lo >= 10) ? 6 : 0;
    thr  = (corr == 0) ? 160 : (sub ? 166 : 154);
    raw  = sub ? int'(a) - int'(b) - int'(xi) : int'(a) + int'(b) + int'(xi);
    c = 1'b0;
    if (raw > 255 || raw < 0 || (raw & 255) >= thr) begin
      c = 1'b1;
      corr = corr | 96;
    end
    raw = raw & 255;
    res = sub ? raw - corr : raw + corr;
    if (res > 255 || res < 0) c = 1'b1;
    res  = res & 255;
    sraw = (raw >= 128) ? raw - 256 : raw;
    sres = sub ? sraw - corr : sraw + corr;
    v  = (sres > 127) || (sres < -128);
    zo = (res != 0) ? 1'b0 : zi;
    return {res[7:0], c, v, zo, res[7]};
  endfunction

  function automatic logic [13:0] mk_exp(input logic dn, input logic [11:0] r);
    return {dn, r[11:4], r[3], r[3], r[2], r[1], r[0]};
  endfunction

  function automatic logic [13:0] observed();
    return {done_q, res_q, c_q, x_q, v_q, z_q, n_q};
  endfunction

  function automatic logic [7:0] to_bcd(input int n);
    return 8'(((n / 10) << 4) | (n % 10));
  endfunction

  task automatic expect_eq(input logic [13:0] got, input logic [13:0] exp,
                           input string tag);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: a=%h b=%h sub=%b x=%b z=%b actual=%h expected=%h",
               tag, opnd_a, opnd_b, op_sub, x_in, z_in, got, exp);
    end
  endtask

  // Drive one operation at a falling edge, check it at the next falling edge.
  task automatic apply_chk(input logic sub, input logic xi, input logic zi,
                           input logic [7:0] a, input logic [7:0] b,
                           input logic [11:0] exp, input string tag);
    op_valid = 1'b1;
    op_sub   = sub;
    x_in     = xi;
    z_in     = zi;
    opnd_a   = a;
    opnd_b   = b;
    @(negedge clk);
    expect_eq(observed(), mk_exp(1'b1, exp), tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog R9: actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [13:0] held;
    nchk = 0;
    nfail = 0;
    finished = 1'b0;
    rst_n = 1'b0;
    op_valid = 1'b0;
    op_sub = 1'b0;
    x_in = 1'b0;
    z_in = 1'b0;
    opnd_a = 8'h00;
    opnd_b = 8'h00;

    // R10: outputs clear while reset is held.
    repeat (3) @(negedge clk);
    expect_eq(observed(), 14'h0, "R10 reset state");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    expect_eq(observed(), 14'h0, "R10 state after release");

    // Hand-worked table: thresholds, correction carry, correction overflow.
    for (int i = 0; i < NVEC; i++) begin
      apply_chk(VEC[i][30], VEC[i][29], VEC[i][28], VEC[i][27:20], VEC[i][19:12],
                VEC[i][11:0], "R1 R2 R3 R4 R5 R6 R7 R8 table");
    end

    // R11: every valid BCD pair against decimal arithmetic and the model.
    for (int s = 0; s < 2; s++) begin
      for (int xv = 0; xv < 2; xv++) begin
        for (int da = 0; da < 100; da++) begin
          for (int db = 0; db < 100; db++) begin
            int dec_val;
            logic dec_c;
            logic zi;
            logic [11:0] exp;
            zi = 1'((da + db) & 1);
            if (s == 1) begin
              dec_val = da - db - xv;
              dec_c = (dec_val < 0);
              if (dec_val < 0) dec_val = dec_val + 100;
            end else begin
              dec_val = da + db + xv;
              dec_c = (dec_val >= 100);
              dec_val = dec_val % 100;
            end
            exp = ref_calc(1'(s), 1'(xv), zi, to_bcd(da), to_bcd(db));
            apply_chk(1'(s), 1'(xv), zi, to_bcd(da), to_bcd(db), exp,
                      "R3 R4 R5 R6 R7 R8 BCD sweep");
            expect_eq({5'b0, res_q, c_q}, {5'b0, to_bcd(dec_val), dec_c},
                      "R11 decimal result");
          end
        end
      end
    end

    // Non-BCD region: every destination byte, one source byte in five.
    for (int s = 0; s < 2; s++) begin
      for (int xv = 0; xv < 2; xv++) begin
        for (int a = 0; a < 256; a++) begin
          for (int b = 0; b < 256; b += 5) begin
            logic zi;
            zi = 1'((a ^ b) & 1);
            apply_chk(1'(s), 1'(xv), zi, 8'(a), 8'(b),
                      ref_calc(1'(s), 1'(xv), zi, 8'(a), 8'(b)),
                      "R1 R2 R3 R4 R5 non-BCD sweep");
          end
        end
      end
    end

    // R9: strobe low, operands changed; every output holds, done drops.
    held = observed();
    op_valid = 1'b0;
    op_sub   = ~op_sub;
    x_in     = ~x_in;
    z_in     = ~z_in;
    opnd_a   = 8'h37;
    opnd_b   = 8'h58;
    @(negedge clk);
    expect_eq(observed(), {1'b0, held[12:0]}, "R9 idle hold");
    opnd_a = 8'h99;
    @(negedge clk);
    expect_eq(observed(), {1'b0, held[12:0]}, "R9 idle hold second cycle");

    // R9: isolated strobe gives a single done pulse.
    apply_chk(1'b0, 1'b0, 1'b1, 8'h25, 8'h48, {8'h73, 4'b0000}, "R9 single strobe");
    op_valid = 1'b0;
    @(negedge clk);
    expect_eq(observed(), {1'b0, 8'h73, 5'b00000}, "R9 done pulse ends");

    // R10: reset in mid-operation clears at once.
    apply_chk(1'b0, 1'b1, 1'b1, 8'h99, 8'h00, {8'h00, 4'b1010}, "R6 R7 before reset");
    op_valid = 1'b0;
    #1 rst_n = 1'b0;
    #1;
    expect_eq(observed(), 14'h0, "R10 asynchronous clear");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    apply_chk(1'b1, 1'b0, 1'b1, 8'h31, 8'h13, {8'h18, 4'b0000}, "R10 resume after reset");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule